// File: doc/BRIEF.md
# Configurable Trigger Interrupt Controller

This block gathers 32 interrupt inputs and turns them into two request lines and one wake line for a processor. Every input has its own trigger setting: off, rising edge, falling edge, both edges, active-high level or active-low level. The setting is a three-bit code whose bits sit in the same bit position of three configuration words. Edges are caught in two sticky status words, one for rising edges and one for falling edges, and stay there until software clears them. Level settings track the input directly.

A source counts as pending only while its enable (mask) bit is set. Each source is routed by a steering bit either to the high-priority request line or to the low-priority line. A third per-source bit lets pending sources also raise the wake line. All inputs pass through a two-flop synchroniser before any detection is done.

Software reaches the configuration over a small synchronous register bus with a combinational read path. Each configuration word has two addresses: a write of ones to the first address sets bits, and a write of ones to the second address clears bits. Zero bits in the write data leave the stored bits alone.

Top module: `trig_intc`

## Requirements
- R1: After reset every stored word reads zero and req_hi, req_lo and wake_out are low.
- R2: Words with set/clear address pairs are trigger bit 0 (0x40/0x44), trigger bit 1 (0x48/0x4C), trigger bit 2 (0x50/0x54), a spare select word (0x58/0x5C), steering (0x60/0x64), wake enable (0x68/0x6C) and mask (0x70/0x74). A write to the first address ORs the data in, a write to the second address removes the data's one bits, and zero bits change nothing; each word reads back at its first address.
- R3: Trigger code {bit2,bit1,bit0} = 101 makes the source pending while its synchronised input is high.
- R4: Trigger code 110 makes the source pending while its synchronised input is low.
- R5: Under code 001 a rising input edge sets the source's bit in the rising status word (read at 0x78), the bit stays set after the input falls, and the falling status word is untouched.
- R6: Under code 010 a falling input edge sets the source's bit in the falling status word (read at 0x7C), and rising edges are not recorded.
- R7: Under code 011 both kinds of edge are recorded and either recorded edge makes the source pending.
- R8: Codes 000, 100 and 111 never make a source pending, and code 000 records no edges.
- R9: Writing a one to a bit at 0x78 or 0x7C clears that status bit, a zero bit has no effect, and an edge detected in the same cycle as the clear stays recorded.
- R10: A source whose mask bit is zero is not pending: it drives no request or wake line and does not show in the pending reads.
- R11: A pending source with steering bit 1 drives req_hi and appears at read address 0x54; with steering bit 0 it drives req_lo and appears at read address 0x5C.
- R12: wake_out is high exactly when some pending source has its wake-enable bit set.
- R13: Address 0x80 holds a plain read/write word that a write replaces in full.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released on the clock |
| bus_addr | input | 8 | Register byte address |
| bus_we | input | 1 | Write strobe, sampled on the rising clock edge |
| bus_wdata | input | 32 | Write data, one bit per source |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| src_in | input | 32 | Asynchronous interrupt inputs |
| req_hi | output | 1 | High-priority request line |
| req_lo | output | 1 | Low-priority request line |
| wake_out | output | 1 | Wake request |

## Verification
The assertions are disabled until the internal reset has been released, two cycles after rst_n rises, so they assume no bus write lands in that window; the stimulus waits several cycles after reset before its first access. They also take the bus address and write strobe as clean at each rising edge, which the stimulus ensures by changing them only on falling edges. Input pins are treated as asynchronous, and every expected value is sampled at least three cycles after an input change so the synchroniser and the edge latch have settled, except in the directed case that lines a clear write up with the edge on purpose.

// File: rtl/trig_intc_pkg.sv
package trig_intc_pkg;

  // Number of words that have a set address and a clear address.
  localparam int unsigned PAIR_CNT = 7;

  // Index of each word in the set/clear bank; address = PAIR_BASE + 8*index.
  localparam int unsigned IX_TRIG0  = 0;
  localparam int unsigned IX_TRIG1  = 1;
  localparam int unsigned IX_TRIG2  = 2;
  localparam int unsigned IX_SPARE  = 3;
  localparam int unsigned IX_STEER  = 4;
  localparam int unsigned IX_WAKE   = 5;
  localparam int unsigned IX_MASK   = 6;

  localparam logic [7:0] PAIR_BASE  = 8'h40;
  localparam logic [7:0] ADR_PEND_H = 8'h54;
  localparam logic [7:0] ADR_PEND_L = 8'h5C;
  localparam logic [7:0] ADR_RISE   = 8'h78;
  localparam logic [7:0] ADR_FALL   = 8'h7C;
  localparam logic [7:0] ADR_TEST   = 8'h80;

  // Trigger code {bit2, bit1, bit0}
  typedef enum logic [2:0] {
    TRIG_OFF  = 3'b000,
    TRIG_RISE = 3'b001,
    TRIG_FALL = 3'b010,
    TRIG_BOTH = 3'b011,
    TRIG_HIGH = 3'b101,
    TRIG_LOW  = 3'b110
  } trig_e;

endpackage

// File: rtl/tic_sync.sv
module tic_sync #(
  parameter int unsigned WIDTH  = 32,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] din,
  output logic [WIDTH-1:0] dout,
  output logic [WIDTH-1:0] dprev
);
  localparam int unsigned DEPTH = STAGES + 1;

  logic [WIDTH-1:0] pipe_q [DEPTH];
  logic [WIDTH-1:0] pipe_d [DEPTH];

  always_comb begin
    pipe_d[0] = din;
    for (int i = 1; i < DEPTH; i++) pipe_d[i] = pipe_q[i-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) pipe_q[i] <= '0;
    end else begin
      for (int i = 0; i < DEPTH; i++) pipe_q[i] <= pipe_d[i];
    end
  end

  assign dout  = pipe_q[STAGES-1];
  assign dprev = pipe_q[STAGES];
endmodule

// File: rtl/tic_regs.sv
module tic_regs
  import trig_intc_pkg::*;
#(
  parameter int unsigned NUM_SRC = 32,
  parameter int unsigned ADDR_W  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [NUM_SRC-1:0] wdata,
  output logic [NUM_SRC-1:0] word_q [PAIR_CNT],
  output logic [NUM_SRC-1:0] test_q
);

  for (genvar g = 0; g < PAIR_CNT; g++) begin : g_pair
    localparam logic [ADDR_W-1:0] SET_A = ADDR_W'(PAIR_BASE + 8 * g);
    localparam logic [ADDR_W-1:0] CLR_A = ADDR_W'(PAIR_BASE + 8 * g + 4);

    logic               hit_set, hit_clr, en;
    logic [NUM_SRC-1:0] val_q, val_d;

    assign hit_set = wr_en && (addr == SET_A);
    assign hit_clr = wr_en && (addr == CLR_A);
    assign en      = hit_set || hit_clr;

    always_comb begin
      val_d = val_q;
      if (hit_set) val_d = val_q | wdata;
      if (hit_clr) val_d = val_q & ~wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  val_q <= '0;
      else if (en) val_q <= val_d;
    end

    assign word_q[g] = val_q;
  end

  logic test_en;
  assign test_en = wr_en && (addr == ADDR_W'(ADR_TEST));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       test_q <= '0;
    else if (test_en) test_q <= wdata;
  end
endmodule

// File: rtl/tic_trig.sv
module tic_trig
  import trig_intc_pkg::*;
#(
  parameter int unsigned NUM_SRC = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] lvl_now,
  input  logic [NUM_SRC-1:0] lvl_prev,
  input  logic [NUM_SRC-1:0] code_b0,
  input  logic [NUM_SRC-1:0] code_b1,
  input  logic [NUM_SRC-1:0] code_b2,
  input  logic [NUM_SRC-1:0] clr_rise,
  input  logic [NUM_SRC-1:0] clr_fall,
  output logic [NUM_SRC-1:0] rise_q,
  output logic [NUM_SRC-1:0] fall_q,
  output logic [NUM_SRC-1:0] pend_raw
);
  logic [NUM_SRC-1:0] rise_d, fall_d, rise_en, fall_en, is_high, is_low;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    logic [2:0] code;
    assign code       = {code_b2[g], code_b1[g], code_b0[g]};
    assign rise_en[g] = (code == TRIG_RISE) || (code == TRIG_BOTH);
    assign fall_en[g] = (code == TRIG_FALL) || (code == TRIG_BOTH);
    assign is_high[g] = (code == TRIG_HIGH);
    assign is_low[g]  = (code == TRIG_LOW);
  end

  // A fresh edge outranks a clear landing in the same cycle.
  assign rise_d = (rise_q & ~clr_rise) | (rise_en &  lvl_now & ~lvl_prev);
  assign fall_d = (fall_q & ~clr_fall) | (fall_en & ~lvl_now &  lvl_prev);

  assign pend_raw = (rise_en & rise_q) | (fall_en & fall_q)
                  | (is_high & lvl_now) | (is_low & ~lvl_now);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rise_q <= '0;
      fall_q <= '0;
    end else begin
      rise_q <= rise_d;
      fall_q <= fall_d;
    end
  end
endmodule

// File: rtl/trig_intc.sv
module trig_intc
  import trig_intc_pkg::*;
#(
  parameter int unsigned NUM_SRC     = 32,
  parameter int unsigned ADDR_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic               bus_we,
  input  logic [NUM_SRC-1:0] bus_wdata,
  output logic [NUM_SRC-1:0] bus_rdata,
  input  logic [NUM_SRC-1:0] src_in,
  output logic               req_hi,
  output logic               req_lo,
  output logic               wake_out
);
  // Reset: asserted asynchronously, released on the clock.
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  logic [NUM_SRC-1:0] lvl_now, lvl_prev;
  tic_sync #(.WIDTH(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_sync_n), .din(src_in), .dout(lvl_now), .dprev(lvl_prev)
  );

  logic [NUM_SRC-1:0] words [PAIR_CNT];
  logic [NUM_SRC-1:0] test_q;
  tic_regs #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(bus_we), .addr(bus_addr),
    .wdata(bus_wdata), .word_q(words), .test_q(test_q)
  );

  logic [NUM_SRC-1:0] cfg0_q, cfg1_q, cfg2_q, spare_q, steer_q, wake_q, mask_q;
  assign cfg0_q  = words[IX_TRIG0];
  assign cfg1_q  = words[IX_TRIG1];
  assign cfg2_q  = words[IX_TRIG2];
  assign spare_q = words[IX_SPARE];
  assign steer_q = words[IX_STEER];
  assign wake_q  = words[IX_WAKE];
  assign mask_q  = words[IX_MASK];

  logic [NUM_SRC-1:0] clr_rise, clr_fall, rise_q, fall_q, pend_raw;
  assign clr_rise = (bus_we && bus_addr == ADDR_W'(ADR_RISE)) ? bus_wdata : '0;
  assign clr_fall = (bus_we && bus_addr == ADDR_W'(ADR_FALL)) ? bus_wdata : '0;

  tic_trig #(.NUM_SRC(NUM_SRC)) u_trig (
    .clk(clk), .rst_n(rst_sync_n), .lvl_now(lvl_now), .lvl_prev(lvl_prev),
    .code_b0(cfg0_q), .code_b1(cfg1_q), .code_b2(cfg2_q),
    .clr_rise(clr_rise), .clr_fall(clr_fall),
    .rise_q(rise_q), .fall_q(fall_q), .pend_raw(pend_raw)
  );

  logic [NUM_SRC-1:0] pend, pend_hi, pend_lo;
  assign pend    = pend_raw & mask_q;
  assign pend_hi = pend & steer_q;
  assign pend_lo = pend & ~steer_q;

  assign req_hi   = |pend_hi;
  assign req_lo   = |pend_lo;
  assign wake_out = |(pend & wake_q);

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      ADDR_W'(8'h40):     bus_rdata = cfg0_q;
      ADDR_W'(8'h48):     bus_rdata = cfg1_q;
      ADDR_W'(8'h50):     bus_rdata = cfg2_q;
      ADDR_W'(ADR_PEND_H): bus_rdata = pend_hi;
      ADDR_W'(8'h58):     bus_rdata = spare_q;
      ADDR_W'(ADR_PEND_L): bus_rdata = pend_lo;
      ADDR_W'(8'h60):     bus_rdata = steer_q;
      ADDR_W'(8'h68):     bus_rdata = wake_q;
      ADDR_W'(8'h70):     bus_rdata = mask_q;
      ADDR_W'(ADR_RISE):  bus_rdata = rise_q;
      ADDR_W'(ADR_FALL):  bus_rdata = fall_q;
      ADDR_W'(ADR_TEST):  bus_rdata = test_q;
      default:            bus_rdata = '0;
    endcase
  end
endmodule

// File: rtl/trig_intc_chk.sv
module trig_intc_chk #(
  parameter int unsigned NUM_SRC = 32,
  parameter int unsigned ADDR_W  = 8
) (
  input logic               clk,
  input logic               rst_ok,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic               bus_we,
  input logic [NUM_SRC-1:0] bus_wdata,
  input logic [NUM_SRC-1:0] cfg0_q,
  input logic [NUM_SRC-1:0] cfg1_q,
  input logic [NUM_SRC-1:0] cfg2_q,
  input logic [NUM_SRC-1:0] steer_q,
  input logic [NUM_SRC-1:0] wake_q,
  input logic [NUM_SRC-1:0] mask_q,
  input logic [NUM_SRC-1:0] rise_q,
  input logic               req_hi,
  input logic               req_lo,
  input logic               wake_out
);

  AST_RESET_QUIET: assert property (@(posedge clk) disable iff (!rst_ok)
    $rose(rst_ok) |-> (!req_hi && !req_lo && !wake_out)); // R1

  AST_MASK_SET: assert property (@(posedge clk) disable iff (!rst_ok)
    (bus_we && bus_addr == ADDR_W'(8'h70)) |=> ((mask_q & $past(bus_wdata)) == $past(bus_wdata))); // R2

  AST_MASK_CLR: assert property (@(posedge clk) disable iff (!rst_ok)
    (bus_we && bus_addr == ADDR_W'(8'h74)) |=> ((mask_q & $past(bus_wdata)) == '0)); // R2

  AST_RISE_STICKY: assert property (@(posedge clk) disable iff (!rst_ok)
    !(bus_we && bus_addr == ADDR_W'(8'h78)) |=> ((rise_q & $past(rise_q)) == $past(rise_q))); // R5

  AST_OFF_SILENT: assert property (@(posedge clk) disable iff (!rst_ok)
    ((cfg0_q | cfg1_q | cfg2_q) == '0) |-> (!req_hi && !req_lo && !wake_out)); // R8

  AST_MASK_GATES: assert property (@(posedge clk) disable iff (!rst_ok)
    (mask_q == '0) |-> (!req_hi && !req_lo && !wake_out)); // R10

  AST_HI_NEEDS_STEER: assert property (@(posedge clk) disable iff (!rst_ok)
    (steer_q == '0) |-> !req_hi); // R11

  AST_WAKE_GATED: assert property (@(posedge clk) disable iff (!rst_ok)
    (wake_q == '0) |-> !wake_out); // R12

endmodule

bind trig_intc trig_intc_chk #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_ok(rst_sync_n), .bus_addr(bus_addr), .bus_we(bus_we),
  .bus_wdata(bus_wdata), .cfg0_q(cfg0_q), .cfg1_q(cfg1_q), .cfg2_q(cfg2_q),
  .steer_q(steer_q), .wake_q(wake_q), .mask_q(mask_q), .rise_q(rise_q),
  .req_hi(req_hi), .req_lo(req_lo), .wake_out(wake_out)
);

// File: tb/trig_intc_test.sv
module trig_intc_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  bus_addr;
  logic        bus_we;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic [31:0] src_in;
  logic        req_hi, req_lo, wake_out;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  trig_intc uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .src_in(src_in),
    .req_hi(req_hi), .req_lo(req_lo), .wake_out(wake_out)
  );

  // {code[2:0], input, mask, steer, wake, exp_hi, exp_lo, exp_wake}
  localparam logic [9:0] VEC [9] = '{
    {3'b101, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0}, // R3 R11
    {3'b101, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0}, // R3
    {3'b110, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1}, // R4 R12
    {3'b110, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0}, // R4
    {3'b101, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0}, // R10
    {3'b000, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0}, // R8
    {3'b100, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0}, // R8
    {3'b111, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0}, // R8
    {3'b110, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0}  // R4 R11
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr  = a;
    bus_wdata = d;
    bus_we    = 1'b1;
    @(negedge clk);
    bus_we    = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic set_code(input int b, input logic [2:0] code);
    wr(8'h44, 32'h1 << b);
    wr(8'h4C, 32'h1 << b);
    wr(8'h54, 32'h1 << b);
    if (code[0]) wr(8'h40, 32'h1 << b);
    if (code[1]) wr(8'h48, 32'h1 << b);
    if (code[2]) wr(8'h50, 32'h1 << b);
  endtask

  task automatic put_bit(input logic [7:0] set_a, input int b, input logic v);
    if (v) wr(set_a, 32'h1 << b);
    else   wr(set_a + 8'h4, 32'h1 << b);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    rst_n = 1'b0; bus_addr = '0; bus_we = 1'b0; bus_wdata = '0; src_in = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    foreach (VEC[i]) begin end
    for (int a = 8'h40; a <= 8'h80; a += 4) begin
      rd(8'(a), d);
      check("R1 read zero", d, 32'h0);
    end
    check("R1 outputs low", {29'h0, req_hi, req_lo, wake_out}, 32'h0);

    // R2: set/clear aliases
    wr(8'h70, 32'hF0F0_0000);
    rd(8'h70, d); check("R2 mask set", d, 32'hF0F0_0000);
    wr(8'h74, 32'h3000_0000);
    rd(8'h70, d); check("R2 mask clear", d, 32'hC0F0_0000);
    wr(8'h70, 32'h0);
    rd(8'h70, d); check("R2 zero write no effect", d, 32'hC0F0_0000);
    wr(8'h74, 32'hFFFF_FFFF);
    rd(8'h70, d); check("R2 mask clear all", d, 32'h0);
    wr(8'h58, 32'h0000_00A5);
    wr(8'h5C, 32'h0000_0005);
    rd(8'h58, d); check("R2 spare set/clear", d, 32'h0000_00A0);
    wr(8'h48, 32'h8000_0001);
    wr(8'h4C, 32'h8000_0000);
    rd(8'h48, d); check("R2 trig1 set/clear", d, 32'h0000_0001);
    wr(8'h4C, 32'hFFFF_FFFF);
    wr(8'h5C, 32'hFFFF_FFFF);

    // R13: plain word
    wr(8'h80, 32'hA5A5_1234);
    rd(8'h80, d); check("R13 test write", d, 32'hA5A5_1234);
    wr(8'h80, 32'h0000_0F00);
    rd(8'h80, d); check("R13 test replace", d, 32'h0000_0F00);

    // Level-mode vector walk on source 5
    for (int i = 0; i < 9; i++) begin
      logic [9:0] v;
      v = VEC[i];
      set_code(5, v[9:7]);
      put_bit(8'h70, 5, v[5]);
      put_bit(8'h60, 5, v[4]);
      put_bit(8'h68, 5, v[3]);
      src_in[5] = v[6];
      settle();
      check("R3/R4/R8/R10 req_hi", {31'h0, req_hi}, {31'h0, v[2]});
      check("R11 req_lo", {31'h0, req_lo}, {31'h0, v[1]});
      check("R12 wake_out", {31'h0, wake_out}, {31'h0, v[0]});
      rd(8'h54, d); check("R11 high pending read", d, {26'h0, v[2], 5'h0});
      rd(8'h5C, d); check("R11 low pending read", d, {26'h0, v[1], 5'h0});
    end
    set_code(5, 3'b000);
    wr(8'h74, 32'h1 << 5);
    src_in[5] = 1'b0;

    // Edge modes on source 9, masked in, steered high
    wr(8'h70, 32'h1 << 9);
    wr(8'h60, 32'h1 << 9);

    // R5 rising
    set_code(9, 3'b001);
    src_in[9] = 1'b1; settle();
    rd(8'h78, d); check("R5 rise latched", d, 32'h1 << 9);
    check("R5 pending", {31'h0, req_hi}, 32'h1);
    src_in[9] = 1'b0; settle();
    rd(8'h78, d); check("R5 sticky", d, 32'h1 << 9);
    rd(8'h7C, d); check("R5 no fall record", d, 32'h0);
    wr(8'h78, 32'h0);
    rd(8'h78, d); check("R9 zero write keeps", d, 32'h1 << 9);
    wr(8'h78, 32'h1 << 9);
    rd(8'h78, d); check("R9 clear rise", d, 32'h0);
    check("R9 request drops", {31'h0, req_hi}, 32'h0);

    // R6 falling
    set_code(9, 3'b010);
    src_in[9] = 1'b1; settle();
    rd(8'h7C, d); check("R6 rise ignored fall", d, 32'h0);
    rd(8'h78, d); check("R6 rise not recorded", d, 32'h0);
    src_in[9] = 1'b0; settle();
    rd(8'h7C, d); check("R6 fall latched", d, 32'h1 << 9);
    check("R6 pending", {31'h0, req_hi}, 32'h1);
    wr(8'h7C, 32'h1 << 9);
    rd(8'h7C, d); check("R9 clear fall", d, 32'h0);

    // R7 both
    set_code(9, 3'b011);
    src_in[9] = 1'b1; settle();
    rd(8'h78, d); check("R7 rise recorded", d, 32'h1 << 9);
    check("R7 pending on rise", {31'h0, req_hi}, 32'h1);
    wr(8'h78, 32'h1 << 9);
    src_in[9] = 1'b0; settle();
    rd(8'h7C, d); check("R7 fall recorded", d, 32'h1 << 9);
    check("R7 pending on fall", {31'h0, req_hi}, 32'h1);
    wr(8'h7C, 32'h1 << 9);

    // R9 race: edge detected in the cycle the clear is written
    @(negedge clk); src_in[9] = 1'b1;
    @(negedge clk);
    wr(8'h78, 32'h1 << 9);
    rd(8'h78, d); check("R9 edge beats clear", d, 32'h1 << 9);
    wr(8'h78, 32'h1 << 9);
    rd(8'h78, d); check("R9 later clear", d, 32'h0);

    // R8 disabled records nothing
    set_code(9, 3'b000);
    src_in[9] = 1'b0; settle();
    src_in[9] = 1'b1; settle();
    src_in[9] = 1'b0; settle();
    rd(8'h78, d); check("R8 no rise record", d, 32'h0);
    rd(8'h7C, d); check("R8 no fall record", d, 32'h0);
    check("R8 no request", {30'h0, req_hi, req_lo}, 32'h0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule